// File: doc/BRIEF.md
# Operand Barrel Shifter with Extended Rotate

This block is the purely combinational shifter that forms the second operand of a 32-bit integer datapath. It takes an operand word, a 3-bit shift kind, an 8-bit shift distance and the current carry flag. In the same cycle it returns the shifted word and a shifter carry-out that the flag logic can store. Typical uses are scaling a table index by four with a left shift of 2, sign-preserving division by powers of two, and word rotation.

Five kinds are supported. There are logical left and right shifts, an arithmetic right shift and a rotate right. The fifth kind is a single-step 33-bit rotate right through the carry flag. The distance is a plain port: the choice between an immediate and a register distance is made upstream, and so is the decoding of the kind. The flag register sits outside the block.

The datapath is a logarithmic right-shift network. Left shifts reuse it by reversing the bit order of the operand on the way in and of the result on the way out. One shared picker supplies the last bit shifted out.

Top module: `opshift_top`

## Requirements
- R1: Kind code 0 (logical left) with distance n in 1..31 returns value shifted left by n with zeros entering at bit 0; the carry-out is value bit 32-n.
- R2: Kind code 1 (logical right) with distance n in 1..31 returns value shifted right by n with zeros entering at bit 31; the carry-out is value bit n-1.
- R3: Kind code 2 (arithmetic right) with distance n in 1..31 fills the vacated upper bits with value bit 31, and the carry-out is value bit n-1. A distance of 32 or more gives every result bit and the carry-out equal to value bit 31.
- R4: Kind code 3 (rotate right) uses the distance modulo 32. For a residue r in 1..31 it returns value rotated right by r, and the carry-out is value bit r-1.
- R5: Kind code 3 with a nonzero distance whose residue modulo 32 is 0 returns value unchanged, and the carry-out is value bit 31.
- R6: Kind code 4 (extended rotate) returns {carry_i, value[31:1]} with carry-out value bit 0, whatever the distance input holds.
- R7: For kind codes 0 to 3, a distance of 0 returns value unchanged, and the carry-out equals carry_i.
- R8: Kind codes 0 and 1 with distance exactly 32 return 0, with carry-out value bit 0 for code 0 and value bit 31 for code 1. With a distance above 32 they return 0 with carry-out 0.
- R9: Kind codes 5, 6 and 7 return value unchanged, and the carry-out equals carry_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| value_i | input | 32 | Operand word to shift |
| kind_i | input | 3 | Shift kind code (0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 extended rotate) |
| amount_i | input | 8 | Shift distance |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench builds the block with its defaults, a 32-bit word and an 8-bit distance. These let the distance run from 0 up to 255, so the exact-32 case, distances beyond 32 and the nonzero multiples of 32 for the rotate (32, 64 and up to 224) are all reachable. Each case is compared with a step-by-step model that moves one bit per iteration. Directed edge distances are followed by a long stream of random kinds, distances, operands and carries, which includes the unused kind codes.

// File: rtl/opshift_pkg.sv
package opshift_pkg;

    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_AMT_W  = 8;
    localparam int unsigned KIND_W     = 3;

    typedef enum logic [KIND_W-1:0] {
        SHK_LSL = 3'd0,
        SHK_LSR = 3'd1,
        SHK_ASR = 3'd2,
        SHK_ROR = 3'd3,
        SHK_RRX = 3'd4
    } shift_kind_e;

    // how the right-shift network fills vacated upper bits
    typedef struct packed {
        logic wrap;      // 1: bits leaving bit 0 re-enter at the top
        logic fill_bit;  // fill value when wrap is 0
    } core_mode_t;

    function automatic logic kind_is_shift(input shift_kind_e k);
        return (k == SHK_LSL) || (k == SHK_LSR) || (k == SHK_ASR) || (k == SHK_ROR);
    endfunction

endpackage

// File: rtl/opshift_core.sv
module opshift_core
    import opshift_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_DATA_W,
    localparam int unsigned SW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] src_i,
    input  logic [SW-1:0]    dist_i,
    input  core_mode_t       mode_i,
    output logic [WIDTH-1:0] dst_o
);

    logic [WIDTH-1:0] stage [0:SW];

    assign stage[0] = src_i;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int unsigned D = 1 << k;
        logic [WIDTH-1:0] moved;
        assign moved = mode_i.wrap
                     ? {stage[k][D-1:0], stage[k][WIDTH-1:D]}
                     : {{D{mode_i.fill_bit}}, stage[k][WIDTH-1:D]};
        assign stage[k+1] = dist_i[k] ? moved : stage[k];
    end

    assign dst_o = stage[SW];

endmodule

// File: rtl/opshift_pick.sv
module opshift_pick
    import opshift_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_DATA_W,
    localparam int unsigned SW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] src_i,
    input  logic [SW-1:0]    dist_i,
    output logic             bit_o
);

    // last bit leaving the low end of a right shift by dist_i (dist_i != 0)
    logic [SW-1:0] idx;

    assign idx   = dist_i - 1'b1;
    assign bit_o = src_i[idx];

endmodule

// File: rtl/opshift_top.sv
module opshift_top
    import opshift_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned AMT_W  = DEF_AMT_W
) (
    input  logic [DATA_W-1:0] value_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic [AMT_W-1:0]  amount_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);

    localparam int unsigned SH_W = $clog2(DATA_W);

    function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
        return r;
    endfunction

    shift_kind_e       kind;
    logic              is_left;
    logic [DATA_W-1:0] net_src;
    logic [DATA_W-1:0] net_dst;
    logic [DATA_W-1:0] net_out;
    core_mode_t        mode;
    logic              last_out;
    logic [SH_W-1:0]   dist_low;
    logic              dist_zero;
    logic              dist_eq_w;
    logic              dist_ge_w;
    logic              low_zero;
    logic              sign;

    assign kind      = shift_kind_e'(kind_i);
    assign is_left   = (kind == SHK_LSL);
    assign sign      = value_i[DATA_W-1];
    assign dist_low  = amount_i[SH_W-1:0];
    assign low_zero  = (dist_low == '0);
    assign dist_zero = (amount_i == '0);
    assign dist_eq_w = (amount_i == AMT_W'(DATA_W));
    assign dist_ge_w = (amount_i >= AMT_W'(DATA_W));

    assign net_src       = is_left ? flip(value_i) : value_i;
    assign mode.wrap     = (kind == SHK_ROR);
    assign mode.fill_bit = (kind == SHK_ASR) ? sign : 1'b0;

    opshift_core #(.WIDTH(DATA_W)) u_core (
        .src_i  (net_src),
        .dist_i (dist_low),
        .mode_i (mode),
        .dst_o  (net_dst)
    );

    opshift_pick #(.WIDTH(DATA_W)) u_pick (
        .src_i  (net_src),
        .dist_i (dist_low),
        .bit_o  (last_out)
    );

    assign net_out = is_left ? flip(net_dst) : net_dst;

    always_comb begin
        result_o = value_i;
        carry_o  = carry_i;
        unique case (kind)
            SHK_LSL, SHK_LSR: begin
                if (dist_zero) begin
                    result_o = value_i;
                    carry_o  = carry_i;
                end else if (dist_eq_w) begin
                    result_o = '0;
                    carry_o  = net_src[DATA_W-1];
                end else if (dist_ge_w) begin
                    result_o = '0;
                    carry_o  = 1'b0;
                end else begin
                    result_o = net_out;
                    carry_o  = last_out;
                end
            end
            SHK_ASR: begin
                if (dist_zero) begin
                    result_o = value_i;
                    carry_o  = carry_i;
                end else if (dist_ge_w) begin
                    result_o = {DATA_W{sign}};
                    carry_o  = sign;
                end else begin
                    result_o = net_out;
                    carry_o  = last_out;
                end
            end
            SHK_ROR: begin
                if (dist_zero) begin
                    result_o = value_i;
                    carry_o  = carry_i;
                end else if (low_zero) begin
                    result_o = value_i;
                    carry_o  = sign;
                end else begin
                    result_o = net_out;
                    carry_o  = last_out;
                end
            end
            SHK_RRX: begin
                result_o = {carry_i, value_i[DATA_W-1:1]};
                carry_o  = value_i[0];
            end
            default: begin
                result_o = value_i;
                carry_o  = carry_i;
            end
        endcase
    end

    // checks on the assembled output against the operand
    always_comb begin
        if (kind == SHK_LSL && !dist_zero && !dist_ge_w)
            assert_lsl_zero_lsb_R1 : assert (result_o[0] == 1'b0);
        if (kind == SHK_LSR && !dist_zero && !dist_ge_w)
            assert_lsr_zero_msb_R2 : assert (result_o[DATA_W-1] == 1'b0);
        if (kind == SHK_ASR)
            assert_asr_sign_kept_R3 : assert (result_o[DATA_W-1] == sign);
        if (kind == SHK_ROR)
            assert_ror_ones_kept_R4 : assert ($countones(result_o) == $countones(value_i));
        if (kind == SHK_RRX)
            assert_rrx_ones_kept_R6 : assert ($countones({carry_o, result_o}) == $countones({carry_i, value_i}));
        if (kind_is_shift(kind) && dist_zero)
            assert_zero_dist_carry_R7 : assert (carry_o == carry_i);
    end

endmodule

// File: tb/opshift_top_bench.sv
module opshift_top_bench;

    logic        clk = 1'b0;
    logic [31:0] value;
    logic [2:0]  kind;
    logic [7:0]  amount;
    logic        cin;
    logic [31:0] result;
    logic        cout;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    opshift_top u_opshift_top (
        .value_i  (value),
        .kind_i   (kind),
        .amount_i (amount),
        .carry_i  (cin),
        .result_o (result),
        .carry_o  (cout)
    );

    // bit-at-a-time reference: returns {carry, result}
    function automatic logic [32:0] model(input logic [2:0] k, input int n,
                                          input logic [31:0] v, input logic c);
        logic [31:0] w = v;
        logic        cy = c;
        int          steps;
        case (k)
            3'd0: begin
                steps = (n > 40) ? 40 : n;
                for (int i = 0; i < steps; i++) begin cy = w[31]; w = w << 1; end
            end
            3'd1: begin
                steps = (n > 40) ? 40 : n;
                for (int i = 0; i < steps; i++) begin cy = w[0]; w = w >> 1; end
            end
            3'd2: begin
                steps = (n > 40) ? 40 : n;
                for (int i = 0; i < steps; i++) begin cy = w[0]; w = {w[31], w[31:1]}; end
            end
            3'd3: begin
                steps = n % 32;
                for (int i = 0; i < steps; i++) begin cy = w[0]; w = {w[0], w[31:1]}; end
                if (n != 0 && steps == 0) cy = w[31];
            end
            3'd4: begin
                cy = v[0];
                w  = {c, v[31:1]};
            end
            default: ;
        endcase
        return {cy, w};
    endfunction

    function automatic string tag_of(input logic [2:0] k, input int n);
        if (k > 3'd4)            return "R9";
        if (k == 3'd4)           return "R6";
        if (n == 0)              return "R7";
        if (k == 3'd3)           return (n % 32 == 0) ? "R5" : "R4";
        if (k == 3'd2)           return "R3";
        if (n >= 32)             return "R8";
        return (k == 3'd0) ? "R1" : "R2";
    endfunction

    task automatic run(input logic [2:0] k, input int n, input logic [31:0] v, input logic c);
        logic [32:0] exp;
        @(negedge clk);
        kind = k; amount = 8'(n); value = v; cin = c;
        exp = model(k, n, v, c);
        @(posedge clk);
        #1;
        checks++;
        if ({cout, result} !== exp) begin
            failures++;
            $display("FAIL %s kind=%0d amt=%0d val=%h cin=%0b: got res=%h c=%0b exp res=%h c=%0b",
                     tag_of(k, n), k, n, v, c, result, cout, exp[31:0], exp[32]);
        end
    endtask

    initial begin
        value = '0; kind = '0; amount = '0; cin = 1'b0;
        // idle inputs: all-zero output
        @(posedge clk); #1;
        checks++;
        if (result !== 32'h0 || cout !== 1'b0) begin
            failures++;
            $display("FAIL R7 idle: got res=%h c=%0b exp res=0 c=0", result, cout);
        end
        // R1: index scale by 4, and edge distances
        run(3'd0, 2,  32'h0000_0007, 1'b0);
        run(3'd0, 1,  32'h8000_0001, 1'b0);
        run(3'd0, 31, 32'h0000_0003, 1'b1);
        // R2
        run(3'd1, 1,  32'h8000_0001, 1'b0);
        run(3'd1, 31, 32'hC000_0000, 1'b0);
        // R3
        run(3'd2, 4,  32'h8000_00F8, 1'b0);
        run(3'd2, 32, 32'h8000_0000, 1'b0);
        run(3'd2, 200, 32'h7FFF_FFFF, 1'b1);
        // R4, R5
        run(3'd3, 8,  32'h1234_5678, 1'b0);
        run(3'd3, 40, 32'h0000_0080, 1'b0);
        run(3'd3, 32, 32'h8000_0000, 1'b0);
        run(3'd3, 224, 32'h7FFF_FFFF, 1'b1);
        // R6: distance ignored
        run(3'd4, 0,   32'h0000_0001, 1'b1);
        run(3'd4, 173, 32'hAAAA_AAAA, 1'b0);
        // R7
        run(3'd0, 0, 32'hDEAD_BEEF, 1'b1);
        run(3'd1, 0, 32'hDEAD_BEEF, 1'b0);
        run(3'd2, 0, 32'h8000_0000, 1'b1);
        run(3'd3, 0, 32'h1234_5678, 1'b1);
        // R8
        run(3'd0, 32, 32'h0000_0001, 1'b0);
        run(3'd1, 32, 32'h8000_0000, 1'b0);
        run(3'd0, 33, 32'hFFFF_FFFF, 1'b1);
        run(3'd1, 255, 32'hFFFF_FFFF, 1'b1);
        // R9
        run(3'd5, 3, 32'hCAFE_F00D, 1'b1);
        run(3'd7, 9, 32'h0F0F_0F0F, 1'b0);
        // random sweep
        for (int i = 0; i < 3000; i++)
            run(3'($urandom), int'($urandom % 256), $urandom, 1'($urandom));
        done = 1'b1;
    end

    initial begin
        for (int cyc = 0; cyc < 150000; cyc++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got running exp finished");
        end
        #2;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule